// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Bank

This block collects up to 32 interrupt sources into one latched cause vector, filters it through a mask, and drives a single interrupt line. Source `i` uses bit `i` in every register of the bank. Hardware raises cause bits with one-cycle event pulses. Software can raise the same bits by writing to a set-only register.

Software reads and writes the bank through a simple word-indexed register port. The write strobe and the read strobe each act on the rising clock edge. Read data is combinational from the current state while the read strobe is high.

A per-bit policy register decides how each cause bit is cleared:
- A bit with policy 0 is cleared by writing 1 to it.
- A bit with policy 1 is cleared when a read returns it.

The mask can be:
- written as a whole word,
- set bit by bit through its own write-1 register,
- cleared bit by bit through another write-1 register.

A read-only view shows the cause bits that are not masked.

Register offsets, in the order the bank lays them out:

| Offset | Register |
|---|---|
| 0 | clear-policy |
| 1 | cause |
| 2 | masked cause |
| 3 | cause set |
| 4 | mask |
| 5 | mask set |
| 6 | mask clear |
| 7 | unused |

Top module: `irq_bank_top`

## Requirements
- R1: After reset the cause is 0, the clear-policy is 0, the mask is all ones and `irq_o` is 0.
- R2: An event pulse on `evt_i[i]` sets cause bit `i` at the next edge. When an event and a clear (by write or by read) hit the same bit in the same cycle, the bit ends set.
- R3: Reading offset 2 returns the cause AND NOT the mask, and `irq_o` is the OR of those bits.
- R4: Writing 1 to bit `i` at offset 1 clears cause bit `i` when its policy bit is 0. Zeros have no effect. Writing 1 to a bit whose policy is 1 has no effect.
- R5: A read of offset 1 or offset 2 clears, at that edge, every returned 1 bit whose policy bit is 1. The read leaves policy-0 bits unchanged.
- R6: Writing 1 to a bit at offset 3 sets that cause bit. Offset 3 reads as 0.
- R7: Offset 4 reads and writes the mask directly. Writing 1s at offset 5 sets mask bits, and writing 1s at offset 6 clears mask bits; zeros in either have no effect. Offsets 5 and 6 read as 0.
- R8: Offset 0 reads and writes the per-bit clear policy, where 0 means write-1-to-clear and 1 means clear-on-read.
- R9: Writing 1 to a bit at offset 2 clears that cause bit only if its policy bit is 0 and its mask bit is 0.
- R10: Offset 7 reads as 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 32 | Per-source hardware event pulses |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (triggers clear-on-read) |
| reg_addr_i | input | 3 | Word offset of the accessed register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the addressed register |
| irq_o | output | 1 | Interrupt request, OR of the unmasked cause bits |

## Verification
The assertions check on every cycle that:
- `irq_o` agrees with the cause and mask state;
- an event or a cause-set write always leaves its bits set at the next edge;
- a mask-set or mask-clear write always takes effect;
- no cause bit rises without an event or a set write.

Only the bench's scenarios show the rest:
- the split between write-1 and clear-on-read behaviour per bit;
- clear-on-read clearing only the returned bits through the masked view;
- the event winning against a simultaneous clear;
- the reads of the write-only and unused offsets.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_POLICY = 3'd0,
        SEL_CAUSE  = 3'd1,
        SEL_MCAUSE = 3'd2,
        SEL_CSET   = 3'd3,
        SEL_MASK   = 3'd4,
        SEL_MSET   = 3'd5,
        SEL_MCLR   = 3'd6,
        SEL_UNUSED = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic wr_policy;
        logic wr_cause;
        logic wr_mcause;
        logic wr_cset;
        logic wr_mask;
        logic wr_mset;
        logic wr_mclr;
        logic rd_cause;
        logic rd_mcause;
    } strobe_t;

endpackage

// File: rtl/irq_bank_decode.sv
module irq_bank_decode
    import irq_bank_pkg::*;
(
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    output strobe_t           strb_o
);
    reg_sel_e sel;

    always_comb begin
        sel              = reg_sel_e'(addr_i);
        strb_o           = '0;
        strb_o.wr_policy = wr_i && (sel == SEL_POLICY);
        strb_o.wr_cause  = wr_i && (sel == SEL_CAUSE);
        strb_o.wr_mcause = wr_i && (sel == SEL_MCAUSE);
        strb_o.wr_cset   = wr_i && (sel == SEL_CSET);
        strb_o.wr_mask   = wr_i && (sel == SEL_MASK);
        strb_o.wr_mset   = wr_i && (sel == SEL_MSET);
        strb_o.wr_mclr   = wr_i && (sel == SEL_MCLR);
        strb_o.rd_cause  = rd_i && (sel == SEL_CAUSE);
        strb_o.rd_mcause = rd_i && (sel == SEL_MCAUSE);
    end
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
    import irq_bank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  strobe_t      strb_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] policy_o,
    output logic [W-1:0] mask_o
);
    typedef struct packed {
        logic [W-1:0] policy;
        logic [W-1:0] mask;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (strb_i.wr_policy) st_d.policy = wdata_i;
        if (strb_i.wr_mask)   st_d.mask   = wdata_i;
        if (strb_i.wr_mset)   st_d.mask   = st_q.mask | wdata_i;
        if (strb_i.wr_mclr)   st_d.mask   = st_q.mask & ~wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.policy <= '0;
            st_q.mask   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign policy_o = st_q.policy;
    assign mask_o   = st_q.mask;
endmodule

// File: rtl/irq_bank_cause.sv
module irq_bank_cause
    import irq_bank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  strobe_t      strb_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] policy_i,
    input  logic [W-1:0] mask_i,
    output logic [W-1:0] cause_o
);
    typedef struct packed {
        logic [W-1:0] cause;
    } cause_state_t;

    cause_state_t st_d, st_q;
    logic [W-1:0] set_v, clr_v;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic w1c_hit, cor_hit;
        always_comb begin
            w1c_hit = !policy_i[i] && wdata_i[i] &&
                      (strb_i.wr_cause || (strb_i.wr_mcause && !mask_i[i]));
            cor_hit = policy_i[i] && st_q.cause[i] &&
                      (strb_i.rd_cause || (strb_i.rd_mcause && !mask_i[i]));
            clr_v[i] = w1c_hit || cor_hit;
            set_v[i] = evt_i[i] || (strb_i.wr_cset && wdata_i[i]);
        end
    end

    always_comb begin
        st_d.cause = (st_q.cause & ~clr_v) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cause_o = st_q.cause;
endmodule

// File: rtl/irq_bank_rdmux.sv
module irq_bank_rdmux
    import irq_bank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [W-1:0]      policy_i,
    input  logic [W-1:0]      cause_i,
    input  logic [W-1:0]      mask_i,
    output logic [W-1:0]      rdata_o
);
    always_comb begin
        unique case (reg_sel_e'(addr_i))
            SEL_POLICY: rdata_o = policy_i;
            SEL_CAUSE:  rdata_o = cause_i;
            SEL_MCAUSE: rdata_o = cause_i & ~mask_i;
            SEL_MASK:   rdata_o = mask_i;
            default:    rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/irq_bank_top.sv
module irq_bank_top
    import irq_bank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      evt_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [W-1:0]      reg_wdata_i,
    output logic [W-1:0]      reg_rdata_o,
    output logic              irq_o
);
    strobe_t      strb;
    logic [W-1:0] policy_q, mask_q, cause_q;

    irq_bank_decode u_decode (
        .wr_i   (reg_wr_i),
        .rd_i   (reg_rd_i),
        .addr_i (reg_addr_i),
        .strb_o (strb)
    );

    irq_bank_ctrl #(.W(W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .strb_i   (strb),
        .wdata_i  (reg_wdata_i),
        .policy_o (policy_q),
        .mask_o   (mask_q)
    );

    irq_bank_cause #(.W(W)) u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .strb_i   (strb),
        .wdata_i  (reg_wdata_i),
        .evt_i    (evt_i),
        .policy_i (policy_q),
        .mask_i   (mask_q),
        .cause_o  (cause_q)
    );

    irq_bank_rdmux #(.W(W)) u_rdmux (
        .addr_i   (reg_addr_i),
        .policy_i (policy_q),
        .cause_i  (cause_q),
        .mask_i   (mask_q),
        .rdata_o  (reg_rdata_o)
    );

    assign irq_o = |(cause_q & ~mask_q);
endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk
    import irq_bank_pkg::*;
#(
    parameter int W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [W-1:0]      evt_i,
    input logic              reg_wr_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [W-1:0]      reg_wdata_i,
    input logic              irq_o,
    input logic [W-1:0]      cause_q,
    input logic [W-1:0]      mask_q
);
    logic          cset_wr;
    logic [W-1:0]  raise_src;

    assign cset_wr   = reg_wr_i && (reg_addr_i == SEL_CSET);
    assign raise_src = evt_i | (cset_wr ? reg_wdata_i : '0);

    // R3: the interrupt line follows the unmasked cause bits
    p_irq_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == |(cause_q & ~mask_q));

    // R2: an event always leaves its bits set, even against a clear
    p_event_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((cause_q & $past(evt_i)) == $past(evt_i)));

    // R6: a cause-set write sets every written 1 bit
    p_cause_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cset_wr |=> ((cause_q & $past(reg_wdata_i)) == $past(reg_wdata_i)));

    // R7: the mask-set alias sets the written bits
    p_mask_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == SEL_MSET)
        |=> ((mask_q & $past(reg_wdata_i)) == $past(reg_wdata_i)));

    // R7: the mask-clear alias clears the written bits
    p_mask_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == SEL_MCLR)
        |=> ((mask_q & $past(reg_wdata_i)) == '0));

    // R2: a cause bit rises only through an event or a cause-set write
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_q & ~$past(cause_q) & ~$past(raise_src)) == '0));
endmodule

bind irq_bank_top irq_bank_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt_i),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .irq_o       (irq_o),
    .cause_q     (cause_q),
    .mask_q      (mask_q)
);

// File: tb/tb_irq_bank_top.sv
module tb_irq_bank_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  evt_i = '0;
    logic          reg_wr_i = 1'b0;
    logic          reg_rd_i = 1'b0;
    logic [2:0]    reg_addr_i = '0;
    logic [W-1:0]  reg_wdata_i = '0;
    logic [W-1:0]  reg_rdata_o;
    logic          irq_o;

    int checks = 0;
    int failures = 0;

    irq_bank_top #(.W(W)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt_i),
        .reg_wr_i    (reg_wr_i),
        .reg_rd_i    (reg_rd_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .irq_o       (irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 1'b0; reg_wdata_i = '0;
    endtask

    task automatic rd_check(input string tag, input logic [2:0] a, input logic [W-1:0] exp);
        @(negedge clk);
        reg_rd_i = 1'b1; reg_addr_i = a;
        #1;
        check(tag, reg_rdata_o, exp);
        @(negedge clk);
        reg_rd_i = 1'b0;
    endtask

    task automatic pulse(input logic [W-1:0] e);
        @(negedge clk);
        evt_i = e;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic t_reset;
        rd_check("R1 policy", 3'd0, 32'h0);
        rd_check("R1 cause", 3'd1, 32'h0);
        rd_check("R1 mask", 3'd4, 32'hFFFF_FFFF);
        check("R1 irq", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_w1c;
        pulse(32'h0000_00F0);
        rd_check("R2 event sets", 3'd1, 32'h0000_00F0);
        check("R3 irq masked", {31'b0, irq_o}, 32'h0);
        wr(3'd6, 32'h0000_0030);
        rd_check("R7 mask clear", 3'd4, 32'hFFFF_FFCF);
        rd_check("R3 masked view", 3'd2, 32'h0000_0030);
        check("R3 irq up", {31'b0, irq_o}, 32'h1);
        wr(3'd1, 32'h0000_0010);
        rd_check("R4 w1c clear", 3'd1, 32'h0000_00E0);
        wr(3'd1, 32'h0);
        rd_check("R4 zeros", 3'd1, 32'h0000_00E0);
        wr(3'd2, 32'h0000_00C0);
        rd_check("R9 masked bits kept", 3'd1, 32'h0000_00E0);
        wr(3'd2, 32'h0000_0020);
        rd_check("R9 unmasked cleared", 3'd1, 32'h0000_00C0);
        wr(3'd5, 32'h0000_0030);
        rd_check("R7 mask set", 3'd4, 32'hFFFF_FFFF);
        check("R3 irq down", {31'b0, irq_o}, 32'h0);
        rd_check("R7 mset reads 0", 3'd5, 32'h0);
        rd_check("R7 mclr reads 0", 3'd6, 32'h0);
        wr(3'd1, 32'h0000_00FF);
        rd_check("R4 clean", 3'd1, 32'h0);
    endtask

    task automatic t_cor;
        wr(3'd0, 32'h0000_000F);
        rd_check("R8 policy rw", 3'd0, 32'h0000_000F);
        wr(3'd3, 32'h0000_003C);
        rd_check("R6 cset reads 0", 3'd3, 32'h0);
        rd_check("R5 first read", 3'd1, 32'h0000_003C);
        rd_check("R5 cor cleared only", 3'd1, 32'h0000_0030);
        wr(3'd3, 32'h0000_0001);
        wr(3'd1, 32'h0000_0001);
        rd_check("R4 w1 on cor bit ignored", 3'd1, 32'h0000_0031);
        rd_check("R5 bit0 cleared", 3'd1, 32'h0000_0030);
        wr(3'd4, 32'hFFFF_FFFD);
        wr(3'd3, 32'h0000_0006);
        rd_check("R5 masked read", 3'd2, 32'h0000_0002);
        rd_check("R5 masked read clears returned only", 3'd1, 32'h0000_0034);
        rd_check("R5 cause read clears", 3'd1, 32'h0000_0030);
        wr(3'd1, 32'h0000_0030);
        rd_check("R4 cleared", 3'd1, 32'h0);
        wr(3'd4, 32'hFFFF_FFFF);
    endtask

    task automatic t_race;
        wr(3'd0, 32'h0000_0200);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_addr_i = 3'd1; reg_wdata_i = 32'h100; evt_i = 32'h100;
        @(negedge clk);
        reg_wr_i = 1'b0; reg_wdata_i = '0; evt_i = '0;
        rd_check("R2 event beats w1c", 3'd1, 32'h0000_0100);
        wr(3'd1, 32'h0000_0100);
        wr(3'd3, 32'h0000_0200);
        @(negedge clk);
        reg_rd_i = 1'b1; reg_addr_i = 3'd1; evt_i = 32'h200;
        #1;
        check("R5 read with event", reg_rdata_o, 32'h0000_0200);
        @(negedge clk);
        reg_rd_i = 1'b0; evt_i = '0;
        rd_check("R2 event beats cor", 3'd1, 32'h0000_0200);
        rd_check("R5 cleared after", 3'd1, 32'h0);
        wr(3'd0, 32'h0);
    endtask

    task automatic t_misc;
        wr(3'd4, 32'h1234_5678);
        rd_check("R7 mask direct", 3'd4, 32'h1234_5678);
        wr(3'd0, 32'h0000_00A5);
        wr(3'd3, 32'h0000_0001);
        wr(3'd7, 32'hFFFF_FFFF);
        rd_check("R10 unused reads 0", 3'd7, 32'h0);
        rd_check("R10 policy untouched", 3'd0, 32'h0000_00A5);
        rd_check("R10 mask untouched", 3'd4, 32'h1234_5678);
        rd_check("R10 cause untouched", 3'd1, 32'h0000_0001);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_w1c();
                t_cor();
                t_race();
                t_misc();
            end
            begin
                repeat (20000) @(posedge clk);
                failures++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule